// File: doc/BRIEF.md
# Cross-Domain Up/Down Occupancy Counter

This block keeps an 8-bit occupancy count, such as the number of filled frame slots in a buffer. Its producer and consumer run on two unrelated clocks. The producer signals "one more" with a single-cycle pulse on its own clock (`clk_a`). The consumer signals "one fewer" with a single-cycle pulse on its clock (`clk_b`). The count register and its flags live entirely in the consumer domain. No flop in the block is clocked by anything other than `clk_a` or `clk_b`.

Each producer pulse flips a toggle flop in `clk_a`. The toggle level is carried into `clk_b` through a two-flop synchronizer. A further flop and an XOR then turn every level change, rising or falling, into one `clk_b` pulse. That pulse is exported, and the counter uses it as its increment request in the same cycle that the pulse is visible.

When an increment and a decrement land in the same `clk_b` cycle, they cancel and the count holds. The count saturates at both ends. A refused step raises a sticky flag, and only reset clears the flags. A single active-high reset asynchronously clears every flop in both domains.

Top module: `xdc_frame_counter`

## Requirements
- R1: While `rst` is high, `count_o`, `inc_pulse_o`, `ovf_o` and `udf_o` are all 0, and reset clears both sticky flags.
- R2: Producer pulses on `inc_a` must be spaced by more than one period of each clock. Under that condition, every pulse yields exactly one `inc_pulse_o` pulse, so the total number of output pulses equals the number of input pulses.
- R3: `inc_pulse_o` rises two to three `clk_b` edges after the `clk_a` edge that samples `inc_a`. The count changes on the `clk_b` edge after that.
- R4: A lone `dec_b` with a count above 0 lowers the count by one on the next `clk_b` edge. A lone increment with a count below 255 raises it by one.
- R5: If `inc_pulse_o` and `dec_b` are both high in the same `clk_b` cycle, the count is unchanged and no flag changes.
- R6: At 255, a lone increment leaves the count at 255 and sets `ovf_o`. `ovf_o` then stays high until reset.
- R7: At 0, a lone decrement leaves the count at 0 and sets `udf_o`. `udf_o` then stays high until reset.
- R8: `inc_pulse_o` is high for a single `clk_b` cycle per transferred event and is never high in two consecutive cycles.
- R9: With no saturation, the settled count equals the number of increments issued minus the number of decrements issued. This holds for `clk_a` slower than, close to, and faster than `clk_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Producer clock |
| clk_b | input | 1 | Consumer clock; the counter's clock |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| inc_a | input | 1 | Increment request, one-cycle pulse in `clk_a` |
| dec_b | input | 1 | Decrement request, one cycle per step in `clk_b` |
| count_o | output | 8 | Current occupancy count (`clk_b`) |
| inc_pulse_o | output | 1 | Increment pulse after transfer into `clk_b` |
| ovf_o | output | 1 | Sticky: an increment was refused at 255 |
| udf_o | output | 1 | Sticky: a decrement was refused at 0 |

## Verification
The bench sweeps `clk_a` from well below to well above `clk_b`, with increments and decrements running in parallel. A synchronizer that lost or doubled a toggle would leave the settled count off by the missing or extra events. It would also leave a mismatch between the number of transferred pulses and the number issued. A long `dec_b` burst overlapping incoming increments forces same-cycle collisions. A counter that let either request win would drift away from the reference on the first collision. Both saturation ends are driven hard, with the opposite flag watched at the same time. A counter that wrapped would jump to 0 or 255 at the ends. A flag that was not sticky would fall back as soon as the request stopped.

// File: rtl/xdc_cnt_pkg.sv
package xdc_cnt_pkg;

    // Width of the occupancy count
    parameter int unsigned XDC_CNT_W = 8;

    typedef logic [XDC_CNT_W-1:0] xdc_cnt_t;

    // Request combination seen by the counter in one clk_b cycle: {up, dn}
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_DN   = 2'b01,
        OP_UP   = 2'b10,
        OP_BOTH = 2'b11
    } xdc_op_e;

    // Registered state of the counter
    typedef struct packed {
        xdc_cnt_t cnt;
        logic     ovf;
        logic     udf;
    } xdc_occ_t;

endpackage

// File: rtl/xdc_toggle_src.sv
// Source side of the pulse transfer: each request pulse inverts a level.
module xdc_toggle_src (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic tog_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (req) begin
            tog_d = ~tog_q;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= tog_d;
    end

    assign tog_o = tog_q;

    // R2: every request changes the toggle level exactly once
    p_toggle_flip_r2: assert property (@(posedge clk) disable iff (rst)
        req |=> (tog_q != $past(tog_q)));

    // R2: no change without a request
    p_toggle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(tog_q));

endmodule

// File: rtl/xdc_sync_chain.sv
// Multi-flop synchronizer for a single level into the destination clock.
module xdc_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[LAST];

    // R3: each stage adds exactly one destination cycle of delay
    for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
        p_stage_shift_r3: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (sh_q[g] == $past(sh_q[g-1])));
    end

endmodule

// File: rtl/xdc_edge_det.sv
// Any-edge detector: one pulse per change of the synchronized level.
module xdc_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign pulse_o = lvl ^ prev_q;

    // R8: after a pulse, the detector has caught up with the level
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> (prev_q == $past(lvl)));

    // R1: detector is quiet while held in reset
    p_rst_quiet_r1: assert property (@(posedge clk)
        rst |-> !pulse_o);

endmodule

// File: rtl/xdc_occ_counter.sv
// Saturating up/down counter with sticky limit flags, single clock domain.
module xdc_occ_counter
    import xdc_cnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     up,
    input  logic     dn,
    output xdc_cnt_t cnt_o,
    output logic     ovf_o,
    output logic     udf_o
);
    localparam xdc_cnt_t CNT_MAX = '1;
    localparam xdc_cnt_t CNT_MIN = '0;
    localparam xdc_cnt_t CNT_ONE = xdc_cnt_t'(1);

    xdc_occ_t st_d, st_q;
    xdc_op_e  op;

    always_comb begin
        op   = xdc_op_e'({up, dn});
        st_d = st_q;
        unique case (op)
            OP_UP: begin
                if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
                else                     st_d.cnt = st_q.cnt + CNT_ONE;
            end
            OP_DN: begin
                if (st_q.cnt == CNT_MIN) st_d.udf = 1'b1;
                else                     st_d.cnt = st_q.cnt - CNT_ONE;
            end
            OP_BOTH: st_d = st_q;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
    assign udf_o = st_q.udf;

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (dn && !up && st_q.cnt != CNT_MIN) |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE));

    p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
        (up && !dn && st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + CNT_ONE));

    p_both_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (up && dn) |=> ($stable(st_q.cnt) && $stable(st_q.ovf) && $stable(st_q.udf)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (up && !dn && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX && st_q.ovf));

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.ovf |=> st_q.ovf);

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (dn && !up && st_q.cnt == CNT_MIN) |=> (st_q.cnt == CNT_MIN && st_q.udf));

    p_udf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.udf |=> st_q.udf);

endmodule

// File: rtl/xdc_frame_counter.sv
// Occupancy counter fed by increments from clk_a and decrements from clk_b.
module xdc_frame_counter
    import xdc_cnt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_a,
    input  logic                 clk_b,
    input  logic                 rst,
    input  logic                 inc_a,
    input  logic                 dec_b,
    output logic [XDC_CNT_W-1:0] count_o,
    output logic                 inc_pulse_o,
    output logic                 ovf_o,
    output logic                 udf_o
);
    logic tog_a;
    logic tog_b;
    logic inc_b;

    xdc_toggle_src u_src (
        .clk   (clk_a),
        .rst   (rst),
        .req   (inc_a),
        .tog_o (tog_a)
    );

    xdc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk_b),
        .rst  (rst),
        .din  (tog_a),
        .dout (tog_b)
    );

    xdc_edge_det u_edge (
        .clk     (clk_b),
        .rst     (rst),
        .lvl     (tog_b),
        .pulse_o (inc_b)
    );

    xdc_occ_counter u_cnt (
        .clk   (clk_b),
        .rst   (rst),
        .up    (inc_b),
        .dn    (dec_b),
        .cnt_o (count_o),
        .ovf_o (ovf_o),
        .udf_o (udf_o)
    );

    assign inc_pulse_o = inc_b;

    // R3: a transferred increment reaches the count on the next clk_b edge
    p_inc_lands_r3: assert property (@(posedge clk_b) disable iff (rst)
        (inc_b && !dec_b && count_o != '1) |=> (count_o != $past(count_o)));

endmodule

// File: tb/xdc_frame_counter_test.sv
`timescale 1ns/1ps
module xdc_frame_counter_test;

    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       rst   = 1'b1;
    logic       inc_a = 1'b0;
    logic       dec_b = 1'b0;
    logic [7:0] count_o;
    logic       inc_pulse_o, ovf_o, udf_o;

    realtime half_a = 3.5;

    always #2.5 clk_b = ~clk_b;        // 200 MHz
    always #(half_a) clk_a = ~clk_a;

    xdc_frame_counter uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
        .inc_a(inc_a), .dec_b(dec_b),
        .count_o(count_o), .inc_pulse_o(inc_pulse_o),
        .ovf_o(ovf_o), .udf_o(udf_o)
    );

    int  vecs = 0, errs = 0;
    int  issued = 0, recvd = 0, decs = 0, both_seen = 0;
    int  m_cnt = 0;
    bit  m_ovf = 0, m_udf = 0, prev_pulse = 0, model_on = 0;

    // Behavioural reference, compared on every clk_b cycle
    always @(negedge clk_b) begin
        if (model_on) begin
            vecs++;
            if (count_o !== m_cnt[7:0] || ovf_o !== m_ovf || udf_o !== m_udf) begin
                errs++;
                $display("FAIL R4/R5/R6/R7 count/ovf/udf actual %0d/%b/%b expected %0d/%b/%b at %0t",
                         count_o, ovf_o, udf_o, m_cnt, m_ovf, m_udf, $time);
            end
            if (inc_pulse_o && prev_pulse) begin
                errs++;
                $display("FAIL R8 pulse high two cycles actual 1 expected 0 at %0t", $time);
            end
            if (inc_pulse_o) recvd++;
            if (recvd > issued) begin
                errs++;
                $display("FAIL R2 extra pulse actual %0d expected <= %0d", recvd, issued);
            end
            if (inc_pulse_o && dec_b) both_seen++;
            if (inc_pulse_o && !dec_b) begin
                if (m_cnt == 255) m_ovf = 1; else m_cnt++;
            end else if (dec_b && !inc_pulse_o) begin
                if (m_cnt == 0) m_udf = 1; else m_cnt--;
            end
            prev_pulse = inc_pulse_o;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        model_on = 0;
        rst = 1'b1;
        inc_a = 1'b0;
        dec_b = 1'b0;
        #20;
        // R1: everything cleared while reset is held
        check(count_o == 0, "R1 count in reset", count_o, 0);
        check(ovf_o == 0 && udf_o == 0, "R1 flags in reset", {ovf_o, udf_o}, 0);
        check(inc_pulse_o == 0, "R1 pulse in reset", inc_pulse_o, 0);
        m_cnt = 0; m_ovf = 0; m_udf = 0; prev_pulse = 0;
        issued = 0; recvd = 0; decs = 0;
        @(negedge clk_b);
        rst = 1'b0;
        model_on = 1;
    endtask

    task automatic send_inc();
        @(negedge clk_a);
        // R3: previous increment must already have arrived
        if (recvd != issued) check(0, "R3 late pulse", recvd, issued);
        inc_a = 1'b1;
        issued++;
        @(negedge clk_a);
        inc_a = 1'b0;
        #30;
    endtask

    task automatic send_dec(input int gap);
        @(posedge clk_b);
        #1 dec_b = 1'b1;
        decs++;
        @(posedge clk_b);
        #1 dec_b = 1'b0;
        repeat (gap) @(posedge clk_b);
    endtask

    task automatic settle_and_check(input int exp, input string tag);
        #120;
        check(recvd == issued, {tag, " R2 pulse total"}, recvd, issued);
        check(count_o == exp[7:0], {tag, " R9 final count"}, count_o, exp);
    endtask

    task automatic mixed_run(input realtime ha);
        half_a = ha;
        do_reset();
        repeat (60) send_inc();
        fork
            repeat (40) send_inc();
            repeat (50) send_dec($urandom_range(12, 0));
        join
        settle_and_check(50, "mixed");
    endtask

    bit done = 0;

    initial begin
        #2ms;
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        // R9: several unrelated ratios, including clk_a faster than clk_b
        mixed_run(3.5);
        mixed_run(1.0);
        mixed_run(6.5);
        mixed_run(1.7);

        // R5: long dec burst while increments keep arriving
        both_seen = 0;
        half_a = 3.5;
        do_reset();
        repeat (50) send_inc();
        fork
            repeat (10) send_inc();
            begin
                @(posedge clk_b);
                #1 dec_b = 1'b1;
                repeat (40) @(posedge clk_b);
                #1 dec_b = 1'b0;
            end
        join
        #120;
        check(both_seen > 0, "R5 collisions seen", both_seen, 1);
        check(count_o == 20, "R5 final count with collisions", count_o, 20);

        // R6: push past the top
        half_a = 1.0;
        do_reset();
        repeat (258) send_inc();
        #60;
        check(count_o == 255, "R6 saturated count", count_o, 255);
        check(ovf_o == 1 && udf_o == 0, "R6 ovf set, udf clear", {ovf_o, udf_o}, 2);

        // R7: drain below zero with dec held every cycle
        @(posedge clk_b);
        #1 dec_b = 1'b1;
        repeat (258) @(posedge clk_b);
        #1 dec_b = 1'b0;
        #20;
        check(count_o == 0, "R7 floor count", count_o, 0);
        check(udf_o == 1, "R7 udf set", udf_o, 1);
        check(ovf_o == 1, "R6 ovf still sticky", ovf_o, 1);

        // R1: reset clears sticky flags
        do_reset();
        #20;
        check(ovf_o == 0 && udf_o == 0, "R1 flags cleared after reset", {ovf_o, udf_o}, 0);

        done = 1;
        model_on = 0;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule